// File: doc/BRIEF.md
# Coarse-Period Up-Counting Timer

This block is a 10-bit up-counter whose behaviour is set by one control byte. The byte holds a freeze bit, a run-enable bit, a count-source code and a coarse period code. The counter advances once per qualifying event. An event is either one cycle of an internal tick enable (six are provided) or a synchronized rising or falling edge on an external pin. The period code is matched against the counter's upper three bits, so the count period is a multiple of 128 events. Code zero selects the full 1024-event range.

A period match produces a sticky match flag, and a wrap past the all-ones count produces a sticky overflow flag. Each flag is cleared by its own write-one-to-clear strobe, and a set in the same cycle wins over the clear. A side input chooses whether a match clears the counter or lets it keep running to the natural wrap. A compare output toggles on every match. When the output is driven and the enable bit rises, the output is first loaded with a programmed start level. The block has no streaming data path, so every pin is a plain level or a single-cycle strobe.

Top module: `coarse_period_timer`

## Requirements
- R1: After reset, `count`, `pmatch_flag`, `ovf_flag` and `cmp_out` are all 0.
- R2: A write with `ctrl_wdata[6]` (enable) going from 0 to 1 clears `count` to 0. While the block is enabled and not frozen, `count` rises by exactly one per selected event.
- R3: With `ctrl_wdata[7]` (freeze) set, events are ignored and `count` keeps its value. Clearing freeze resumes counting from that retained value.
- R4: With enable at 0, `count` keeps its residual value and ignores all events.
- R5: Source codes 0 to 5 in `ctrl_wdata[5:3]` select `int_tick[code]` as the event, and the other tick inputs have no effect.
- R6: Source code 6 counts rising edges of `ext_pin` and code 7 counts its falling edges, after a two-flop synchronizer. Internal ticks have no effect under these codes.
- R7: With `keep_on_match`=0 and period code c in 1..7 (`ctrl_wdata[2:0]`), the event that would bring `count` to c*128 instead clears it to 0 and sets `pmatch_flag`.
- R8: With period code 0, the match happens at the wrap from 1023 to 0, which sets both `pmatch_flag` and `ovf_flag`.
- R9: With `keep_on_match`=1, a match sets `pmatch_flag` but does not clear `count`. The counter runs on to 1023 and wraps to 0, setting `ovf_flag`.
- R10: The flags are sticky. A one-cycle `pmatch_clr` or `ovf_clr` clears the matching flag, and a set in the same cycle wins.
- R11: While `out_drive_en`=1, `cmp_out` takes `out_init` at each enable rise and toggles on each match. While `out_drive_en`=0, `cmp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | [7] freeze, [6] enable, [5:3] source, [2:0] period code |
| keep_on_match | input | 1 | 1: a period match does not clear the counter |
| out_drive_en | input | 1 | Enables the compare output |
| out_init | input | 1 | Level loaded into the compare output at enable rise |
| int_tick | input | 6 | Internal tick enables, one per source code 0..5 |
| ext_pin | input | 1 | Asynchronous external count pin |
| pmatch_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | 10 | Current counter value |
| pmatch_flag | output | 1 | Sticky period-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_out | output | 1 | Compare output |

## Verification
The bound checker watches four rules on every cycle. The count must stay put while the block is disabled or frozen. An enable rise must leave a zero count. The count may only hold, step by one, or drop to zero. A set flag must stay set until its clear strobe arrives. Other behaviours only show up in the bench's scenarios. These are which source each code selects, the exact event on which a match fires for each of the eight period codes, the wrap and overflow under both match policies, the set-over-clear priority, and the start level and toggling of the compare output.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int SRC_W  = 3;
  localparam int CODE_W = 3;
  localparam int N_SRC  = 1 << SRC_W;
  localparam int N_INT  = N_SRC - 2;

  typedef struct packed {
    logic              freeze;
    logic              enable;
    logic [SRC_W-1:0]  src;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cpt_src_sel.sv
module cpt_src_sel
  import cpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [N_INT-1:0] int_tick,
  input  logic             ext_pin,
  output logic             tick
);
  logic [2:0]       sync_q;
  logic             pin_rise;
  logic             pin_fall;
  logic [N_SRC-1:0] cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_pin};
  end

  assign pin_rise = sync_q[1] & ~sync_q[2];
  assign pin_fall = ~sync_q[1] & sync_q[2];

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    assign cand[i] = int_tick[i];
  end
  assign cand[N_SRC-2] = pin_rise;
  assign cand[N_SRC-1] = pin_fall;

  assign tick = cand[src];
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter
  import cpt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              freeze,
  input  logic [CODE_W-1:0] code,
  input  logic              keep_on_match,
  input  logic              tick,
  output logic [CNT_W-1:0]  count,
  output logic              on_rise,
  output logic              match_evt,
  output logic              ovf_evt
);
  localparam int LOW_W = CNT_W - CODE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             en_d;
  logic             step;
  logic             at_top;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= enable;
  end

  assign on_rise = enable & ~en_d;
  assign step    = enable & ~freeze & tick & ~on_rise;
  assign nxt     = cnt_q + 1'b1;
  assign at_top  = &cnt_q;

  always_comb begin
    if (code == '0) hit = at_top;
    else            hit = (nxt[CNT_W-1 -: CODE_W] == code) && (nxt[LOW_W-1:0] == '0);
  end

  assign match_evt = step & hit;
  assign ovf_evt   = step & at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (on_rise)                    cnt_q <= '0;
    else if (match_evt && !keep_on_match) cnt_q <= '0;
    else if (step)                       cnt_q <= nxt;
  end

  assign count = cnt_q;
endmodule

// File: rtl/cpt_sticky.sv
module cpt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_strobe,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (set_evt)    flag <= 1'b1;
    else if (clr_strobe) flag <= 1'b0;
  end
endmodule

// File: rtl/cpt_cmp_out.sv
module cpt_cmp_out (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_en,
  input  logic init_lvl,
  input  logic on_rise,
  input  logic match_evt,
  output logic pin
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     out_q <= 1'b0;
    else if (drive_en && on_rise)   out_q <= init_lvl;
    else if (drive_en && match_evt) out_q <= ~out_q;
  end

  assign pin = drive_en & out_q;
endmodule

// File: rtl/coarse_period_timer.sv
module coarse_period_timer
  import cpt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              keep_on_match,
  input  logic              out_drive_en,
  input  logic              out_init,
  input  logic [N_INT-1:0]  int_tick,
  input  logic              ext_pin,
  input  logic              pmatch_clr,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count,
  output logic              pmatch_flag,
  output logic              ovf_flag,
  output logic              cmp_out
);
  localparam int N_FLAGS = 2;

  ctrl_t              ctrl_q;
  logic               en_q;
  logic               freeze_q;
  logic               tick;
  logic               on_rise;
  logic               match_evt;
  logic               ovf_evt;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  assign en_q     = ctrl_q.enable;
  assign freeze_q = ctrl_q.freeze;

  cpt_src_sel u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (ctrl_q.src),
    .int_tick (int_tick),
    .ext_pin  (ext_pin),
    .tick     (tick)
  );

  cpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (en_q),
    .freeze        (freeze_q),
    .code          (ctrl_q.code),
    .keep_on_match (keep_on_match),
    .tick          (tick),
    .count         (count),
    .on_rise       (on_rise),
    .match_evt     (match_evt),
    .ovf_evt       (ovf_evt)
  );

  assign flag_set = {ovf_evt, match_evt};
  assign flag_clr = {ovf_clr, pmatch_clr};

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    cpt_sticky u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_evt    (flag_set[f]),
      .clr_strobe (flag_clr[f]),
      .flag       (flag_q[f])
    );
  end

  assign pmatch_flag = flag_q[0];
  assign ovf_flag    = flag_q[1];

  cpt_cmp_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_en  (out_drive_en),
    .init_lvl  (out_init),
    .on_rise   (on_rise),
    .match_evt (match_evt),
    .pin       (cmp_out)
  );
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             freeze_q,
  input logic             on_rise,
  input logic [CNT_W-1:0] count,
  input logic             pmatch_flag,
  input logic             pmatch_clr,
  input logic             ovf_flag,
  input logic             ovf_clr
);
  a_r4_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(count));

  a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && freeze_q && !on_rise) |=> $stable(count));

  a_r2_rise_zero: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |=> (count == '0));

  a_r2_step_shape: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0)));

  a_r10_pmatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pmatch_flag && !pmatch_clr) |=> pmatch_flag);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind coarse_period_timer cpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_q        (en_q),
  .freeze_q    (freeze_q),
  .on_rise     (on_rise),
  .count       (count),
  .pmatch_flag (pmatch_flag),
  .pmatch_clr  (pmatch_clr),
  .ovf_flag    (ovf_flag),
  .ovf_clr     (ovf_clr)
);

// File: tb/coarse_period_timer_tb.sv
module coarse_period_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       keep_on_match = 1'b0;
  logic       out_drive_en = 1'b0;
  logic       out_init = 1'b0;
  logic [5:0] int_tick = '0;
  logic       ext_pin = 1'b0;
  logic       pmatch_clr = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [9:0] count;
  logic       pmatch_flag;
  logic       ovf_flag;
  logic       cmp_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coarse_period_timer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .ctrl_wdata    (ctrl_wdata),
    .keep_on_match (keep_on_match),
    .out_drive_en  (out_drive_en),
    .out_init      (out_init),
    .int_tick      (int_tick),
    .ext_pin       (ext_pin),
    .pmatch_clr    (pmatch_clr),
    .ovf_clr       (ovf_clr),
    .count         (count),
    .pmatch_flag   (pmatch_flag),
    .ovf_flag      (ovf_flag),
    .cmp_out       (cmp_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit frz, input bit en, input int src, input int code);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = {frz, en, 3'(src), 3'(code)};
    @(negedge clk);
    ctrl_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic restart(input int src, input int code);
    wr(1'b0, 1'b0, src, code);
    wr(1'b0, 1'b1, src, code);
  endtask

  task automatic ticks(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      int_tick[idx] = 1'b1;
      @(negedge clk);
      int_tick[idx] = 1'b0;
    end
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk);
    pmatch_clr = 1'b1;
    ovf_clr    = 1'b1;
    @(negedge clk);
    pmatch_clr = 1'b0;
    ovf_clr    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 pmatch", pmatch_flag, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 cmp_out", cmp_out, 0);

    keep_on_match = 1'b1;
    out_drive_en  = 1'b1;
    wr(1'b0, 1'b1, 1, 0);
    chk("R2 count after enable", count, 0);
    ticks(1, 100);
    chk("R2 counted ticks", count, 100);

    // R3 freeze and resume
    wr(1'b1, 1'b1, 1, 0);
    ticks(1, 30);
    chk("R3 frozen", count, 100);
    wr(1'b0, 1'b1, 1, 0);
    ticks(1, 5);
    chk("R3 resumed", count, 105);

    // R4 disabled retains
    wr(1'b0, 1'b0, 1, 0);
    ticks(1, 20);
    chk("R4 disabled retains", count, 105);
    wr(1'b0, 1'b1, 1, 0);
    chk("R2 enable rise clears", count, 0);

    // R5 source sweep over internal ticks
    acc = 0;
    for (int s = 0; s < 6; s++) begin
      wr(1'b0, 1'b1, s, 0);
      for (int i = 0; i < 6; i++) ticks(i, i + 1);
      acc += s + 1;
      chk($sformatf("R5 source %0d", s), count, acc);
    end

    // R6 external edges
    wr(1'b0, 1'b1, 6, 0);
    ticks(1, 10);
    chk("R6 internal ignored", count, acc);
    pin_pulses(7);
    acc += 7;
    chk("R6 rising edges", count, acc);
    wr(1'b0, 1'b1, 7, 0);
    pin_pulses(5);
    acc += 5;
    chk("R6 falling edges", count, acc);

    // R7 period codes with clear on match, R11 toggling
    keep_on_match = 1'b0;
    out_init      = 1'b0;
    for (int c = 1; c < 8; c++) begin
      restart(1, c);
      clr_flags();
      chk($sformatf("R11 init level c%0d", c), cmp_out, 0);
      ticks(1, c * 128 - 1);
      chk($sformatf("R7 before match c%0d", c), count, c * 128 - 1);
      chk($sformatf("R7 no flag yet c%0d", c), pmatch_flag, 0);
      ticks(1, 1);
      chk($sformatf("R7 cleared c%0d", c), count, 0);
      chk($sformatf("R7 flag c%0d", c), pmatch_flag, 1);
      chk($sformatf("R11 toggled c%0d", c), cmp_out, 1);
      ticks(1, c * 128);
      chk($sformatf("R7 second period c%0d", c), count, 0);
      chk($sformatf("R11 toggled back c%0d", c), cmp_out, 0);
    end

    // R10 clear and set-wins
    clr_flags();
    chk("R10 cleared", pmatch_flag, 0);
    restart(1, 1);
    ticks(1, 127);
    @(negedge clk);
    int_tick[1] = 1'b1;
    pmatch_clr  = 1'b1;
    @(negedge clk);
    int_tick[1] = 1'b0;
    pmatch_clr  = 1'b0;
    chk("R10 set wins", pmatch_flag, 1);
    chk("R10 count cleared", count, 0);

    // R8 full range with code zero
    restart(1, 0);
    clr_flags();
    ticks(1, 1023);
    chk("R8 top", count, 1023);
    chk("R8 no match yet", pmatch_flag, 0);
    chk("R8 no ovf yet", ovf_flag, 0);
    ticks(1, 1);
    chk("R8 wrapped", count, 0);
    chk("R8 match", pmatch_flag, 1);
    chk("R8 ovf", ovf_flag, 1);

    // R9 keep running through match
    keep_on_match = 1'b1;
    restart(1, 2);
    clr_flags();
    ticks(1, 256);
    chk("R9 not cleared", count, 256);
    chk("R9 match flag", pmatch_flag, 1);
    chk("R9 no ovf", ovf_flag, 0);
    ticks(1, 767);
    chk("R9 top", count, 1023);
    chk("R9 still no ovf", ovf_flag, 0);
    ticks(1, 1);
    chk("R9 wrap", count, 0);
    chk("R9 ovf", ovf_flag, 1);

    // R11 init level one, drive disable
    out_init = 1'b1;
    restart(1, 2);
    chk("R11 init one", cmp_out, 1);
    out_drive_en = 1'b0;
    @(negedge clk);
    chk("R11 drive off", cmp_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule